// File: doc/BRIEF.md
# SRAM-Emulated Ternary Match Engine

This block gives ternary content-addressable lookup built only from small lookup tables and gates. No stored entry is ever compared against the search key. The key is cut into equal sub-words. Each sub-word is used as a read address into three kinds of table per partition:
- a presence bit, set when some entry in that partition can hold that sub-word value;
- a link word, which selects a bitmap row;
- a bitmap row, with one bit per entry slot.

The table space is also split by entry address into layers. Each layer holds a contiguous run of slots. Inside a layer, every presence bit must be set and the bitmap rows are ANDed together. The lowest surviving slot is the layer's candidate. A second encoder then chooses the lowest layer that has a candidate.

Entries are written through a mapping port. The port takes a value, a care mask and an entry address. The block walks every sub-word value once and expands each don't-care position into both of its binary values. While this walk runs, the block reports busy and accepts no search. Searches are accepted at up to one per clock cycle. Each result returns a fixed two cycles after its key, whatever the table contents.

Top module: `tcam_sram_lookup`

## Requirements
- R1: After reset, `busy` and `res_valid` are low and every search key misses, because all tables start empty.
- R2: A search is accepted when `srch_valid` is high while `busy` is low. Exactly one result appears with `res_valid` high two cycles later. Accepted searches in consecutive cycles produce results in consecutive cycles, in the same order.
- R3: A mapping request is accepted when `map_valid` is high while `busy` is low. `busy` then stays high for exactly 2^SUB_W cycles, starting in the next cycle. A search or mapping request offered while `busy` is high is dropped: it produces no result and changes no table.
- R4: A `map_care` bit of 1 means the key bit must equal the `map_key` bit. A search key matches an entry when all of that entry's care bits agree with the key.
- R5: A care bit of 0 is a don't-care. Such an entry matches every key that agrees on the care bits. For example, value 0100 with mask 1100 matches 0100 through 0111.
- R6: When several entries in one layer match, the lowest entry address wins.
- R7: When matches exist in several layers, the lowest-numbered layer wins. Layer numbers rise with entry address.
- R8: A miss returns `res_hit` low and `res_addr` equal to 0.
- R9: Entry address a is stored in layer a / LAYER_SLOTS, at slot a mod LAYER_SLOTS. A hit reports that same address a on `res_addr`.
- R10: A key misses when each of its sub-words occurs in some entry of a layer but no single entry matches all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all tables |
| map_valid | input | 1 | Request to write one ternary entry |
| map_addr | input | $clog2(NUM_LAYERS*LAYER_SLOTS) | Entry address to write |
| map_key | input | KEY_W | Entry value |
| map_care | input | KEY_W | Care mask; 1 = compare, 0 = don't care |
| busy | output | 1 | Mapping walk in progress; requests are dropped |
| srch_valid | input | 1 | Search key present |
| srch_key | input | KEY_W | Key to look up |
| res_valid | output | 1 | Result present, two cycles after the accepted key |
| res_hit | output | 1 | At least one entry matched |
| res_addr | output | $clog2(NUM_LAYERS*LAYER_SLOTS) | Lowest matching entry address, 0 on a miss |

## Verification
The hardest case is a key that no single entry matches, yet whose every sub-word value is present in one layer's partitions. Only the bitmap AND can reject that key. To reach it, the bench puts two exact entries with disjoint sub-word values into layer 0. It then searches the keys built from one sub-word of each entry. A second hard case is traffic offered during a mapping walk. The bench injects a search and a conflicting mapping request in the first busy cycle. It then shows, through later searches and the result stream, that neither one took effect.

// File: rtl/tcam_lookup_pkg.sv
package tcam_lookup_pkg;

   // True when a candidate sub-word value agrees with a pattern on every cared bit.
   function automatic logic sub_covers(input logic [31:0] cand,
                                       input logic [31:0] pat,
                                       input logic [31:0] care);
      return ((cand ^ pat) & care) == 32'd0;
   endfunction

endpackage

// File: rtl/tcam_prio.sv
module tcam_prio #(
   parameter int WIDTH = 2
) (
   input  logic [WIDTH-1:0]         vec,
   output logic                     any,
   output logic [$clog2(WIDTH)-1:0] idx
);
   localparam int IW = $clog2(WIDTH);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("tcam_prio needs WIDTH >= 2");
      end
   endgenerate

   // Lowest set index wins: scan from the top so lower indices overwrite.
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/tcam_part.sv
module tcam_part #(
   parameter int SUB_W = 2,
   parameter int SLOTS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUB_W-1:0] rd_sub,
   output logic             rd_present,
   output logic [SLOTS-1:0] rd_bits,
   input  logic             wr_en,
   input  logic [SUB_W-1:0] wr_sub,
   input  logic [SLOTS-1:0] wr_slot
);
   localparam int ROWS = 1 << SUB_W;

   logic             present_q [ROWS];
   logic [SUB_W-1:0] link_q    [ROWS];
   logic [SLOTS-1:0] bits_q    [ROWS];
   logic [SUB_W-1:0] fresh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) begin
            present_q[r] <= 1'b0;
            link_q[r]    <= '0;
            bits_q[r]    <= '0;
         end
         fresh_q <= '0;
      end else if (wr_en) begin
         if (!present_q[wr_sub]) begin
            present_q[wr_sub] <= 1'b1;
            link_q[wr_sub]    <= fresh_q;
            bits_q[fresh_q]   <= bits_q[fresh_q] | wr_slot;
            fresh_q           <= fresh_q + 1'b1;
         end else begin
            bits_q[link_q[wr_sub]] <= bits_q[link_q[wr_sub]] | wr_slot;
         end
      end
   end

   always_comb begin
      rd_present = present_q[rd_sub];
      rd_bits    = rd_present ? bits_q[link_q[rd_sub]] : '0;
   end
endmodule

// File: rtl/tcam_layer.sv
module tcam_layer #(
   parameter int SUB_W   = 2,
   parameter int NUM_SUB = 2,
   parameter int SLOTS   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SUB*SUB_W-1:0] key,
   output logic                     hit,
   output logic [$clog2(SLOTS)-1:0] pma,
   input  logic                     wr_en,
   input  logic [NUM_SUB-1:0]       wr_sel,
   input  logic [SUB_W-1:0]         wr_sub,
   input  logic [SLOTS-1:0]         wr_slot
);
   logic [NUM_SUB-1:0] seen;
   logic [SLOTS-1:0]   rows [NUM_SUB];
   logic [SLOTS-1:0]   joined;
   logic [SLOTS-1:0]   cand;

   generate
      for (genvar n = 0; n < NUM_SUB; n++) begin : g_part
         tcam_part #(.SUB_W(SUB_W), .SLOTS(SLOTS)) u_part (
            .clk        (clk),
            .rst_n      (rst_n),
            .rd_sub     (key[n*SUB_W +: SUB_W]),
            .rd_present (seen[n]),
            .rd_bits    (rows[n]),
            .wr_en      (wr_en && wr_sel[n]),
            .wr_sub     (wr_sub),
            .wr_slot    (wr_slot)
         );
      end
   endgenerate

   always_comb begin
      joined = '1;
      for (int n = 0; n < NUM_SUB; n++) joined &= rows[n];
      cand = (&seen) ? joined : '0;
   end

   tcam_prio #(.WIDTH(SLOTS)) u_slot_enc (
      .vec (cand),
      .any (hit),
      .idx (pma)
   );
endmodule

// File: rtl/tcam_sram_lookup.sv
module tcam_sram_lookup #(
   parameter int KEY_W       = 4,
   parameter int SUB_W       = 2,
   parameter int NUM_LAYERS  = 2,
   parameter int LAYER_SLOTS = 2
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic                                      map_valid,
   input  logic [$clog2(NUM_LAYERS*LAYER_SLOTS)-1:0] map_addr,
   input  logic [KEY_W-1:0]                          map_key,
   input  logic [KEY_W-1:0]                          map_care,
   output logic                                      busy,
   input  logic                                      srch_valid,
   input  logic [KEY_W-1:0]                          srch_key,
   output logic                                      res_valid,
   output logic                                      res_hit,
   output logic [$clog2(NUM_LAYERS*LAYER_SLOTS)-1:0] res_addr
);
   localparam int NUM_SUB = KEY_W / SUB_W;
   localparam int ROWS    = 1 << SUB_W;
   localparam int PW      = $clog2(LAYER_SLOTS);
   localparam int LW      = $clog2(NUM_LAYERS);
   localparam int AW      = $clog2(NUM_LAYERS * LAYER_SLOTS);

   generate
      if (KEY_W != SUB_W * NUM_SUB) begin : g_bad_split
         $error("KEY_W must be a whole multiple of SUB_W");
      end
      if (LAYER_SLOTS < 2 || (1 << PW) != LAYER_SLOTS) begin : g_bad_slots
         $error("LAYER_SLOTS must be a power of two, at least 2");
      end
      if (NUM_LAYERS < 2 || AW != LW + PW) begin : g_bad_layers
         $error("NUM_LAYERS must be at least 2");
      end
   endgenerate

   // Mapping walk: one sub-word value per cycle, all partitions of the target layer.
   logic             busy_q;
   logic [SUB_W-1:0] scan_q;
   logic [KEY_W-1:0] pat_q;
   logic [KEY_W-1:0] care_q;
   logic [AW-1:0]    dst_q;
   logic             map_go;
   logic             srch_go;

   assign map_go  = map_valid && !busy_q;
   assign srch_go = srch_valid && !busy_q;
   assign busy    = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         scan_q <= '0;
         pat_q  <= '0;
         care_q <= '0;
         dst_q  <= '0;
      end else if (map_go) begin
         busy_q <= 1'b1;
         scan_q <= '0;
         pat_q  <= map_key;
         care_q <= map_care;
         dst_q  <= map_addr;
      end else if (busy_q) begin
         scan_q <= scan_q + 1'b1;
         if (scan_q == SUB_W'(ROWS - 1)) busy_q <= 1'b0;
      end
   end

   logic [NUM_SUB-1:0]     wr_sel;
   logic [LAYER_SLOTS-1:0] wr_slot;
   logic [AW-PW-1:0]       wr_layer;

   always_comb begin
      for (int n = 0; n < NUM_SUB; n++) begin
         wr_sel[n] = tcam_lookup_pkg::sub_covers(32'(scan_q),
                                                 32'(pat_q[n*SUB_W +: SUB_W]),
                                                 32'(care_q[n*SUB_W +: SUB_W]));
      end
      wr_slot  = LAYER_SLOTS'(1) << dst_q[PW-1:0];
      wr_layer = dst_q[AW-1:PW];
   end

   // Layers read the live key; their candidates are registered (stage 1).
   logic [NUM_LAYERS-1:0] hit_w;
   logic [PW-1:0]         pma_w [NUM_LAYERS];

   generate
      for (genvar l = 0; l < NUM_LAYERS; l++) begin : g_layer
         tcam_layer #(.SUB_W(SUB_W), .NUM_SUB(NUM_SUB), .SLOTS(LAYER_SLOTS)) u_layer (
            .clk     (clk),
            .rst_n   (rst_n),
            .key     (srch_key),
            .hit     (hit_w[l]),
            .pma     (pma_w[l]),
            .wr_en   (busy_q && (wr_layer == (AW-PW)'(l))),
            .wr_sel  (wr_sel),
            .wr_sub  (scan_q),
            .wr_slot (wr_slot)
         );
      end
   endgenerate

   logic                  s1_valid_q;
   logic [NUM_LAYERS-1:0] lay_hit_q;
   logic [PW-1:0]         lay_pma_q [NUM_LAYERS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid_q <= 1'b0;
         lay_hit_q  <= '0;
         for (int l = 0; l < NUM_LAYERS; l++) lay_pma_q[l] <= '0;
      end else begin
         s1_valid_q <= srch_go;
         lay_hit_q  <= hit_w;
         for (int l = 0; l < NUM_LAYERS; l++) lay_pma_q[l] <= pma_w[l];
      end
   end

   // Stage 2: choose the lowest layer with a candidate.
   logic          top_any;
   logic [LW-1:0] top_idx;

   tcam_prio #(.WIDTH(NUM_LAYERS)) u_layer_enc (
      .vec (lay_hit_q),
      .any (top_any),
      .idx (top_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_hit   <= 1'b0;
         res_addr  <= '0;
      end else begin
         res_valid <= s1_valid_q;
         res_hit   <= s1_valid_q && top_any;
         res_addr  <= (s1_valid_q && top_any) ? AW'({top_idx, lay_pma_q[top_idx]}) : '0;
      end
   end
endmodule

// File: rtl/tcam_sram_lookup_chk.sv
module tcam_sram_lookup_chk #(
   parameter int ROWS = 4,
   parameter int AW   = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          map_valid,
   input logic          srch_valid,
   input logic          busy,
   input logic          res_valid,
   input logic          res_hit,
   input logic [AW-1:0] res_addr
);
   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !res_hit);

   assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_valid && !busy) |-> ##2 res_valid);

   assert_no_orphan_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(srch_valid && !busy, 2));

   assert_map_starts_walk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (map_valid && !busy) |=> busy);

   assert_walk_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_run < ROWS);

   assert_walk_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_run == ROWS);

   assert_miss_zero_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> res_addr == '0);
endmodule

bind tcam_sram_lookup tcam_sram_lookup_chk #(.ROWS(ROWS), .AW(AW)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .map_valid  (map_valid),
   .srch_valid (srch_valid),
   .busy       (busy),
   .res_valid  (res_valid),
   .res_hit    (res_hit),
   .res_addr   (res_addr)
);

// File: tb/test_tcam_sram_lookup.sv
`timescale 1ns/1ps
module test_tcam_sram_lookup;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       map_valid = 1'b0;
   logic [1:0] map_addr = '0;
   logic [3:0] map_key = '0;
   logic [3:0] map_care = '0;
   logic       busy;
   logic       srch_valid = 1'b0;
   logic [3:0] srch_key = '0;
   logic       res_valid;
   logic       res_hit;
   logic [1:0] res_addr;

   always #5 clk = ~clk;

   tcam_sram_lookup i_tcam_sram_lookup (
      .clk(clk), .rst_n(rst_n),
      .map_valid(map_valid), .map_addr(map_addr), .map_key(map_key), .map_care(map_care),
      .busy(busy),
      .srch_valid(srch_valid), .srch_key(srch_key),
      .res_valid(res_valid), .res_hit(res_hit), .res_addr(res_addr)
   );

   int checks = 0;
   int fails  = 0;

   // Reference table: value, care mask, written flag per entry address.
   logic [3:0] m_key  [4];
   logic [3:0] m_care [4];
   logic       m_on   [4];

   logic [2:0] exp_q [$];
   string      tag_q [$];

   function automatic logic [2:0] model(input logic [3:0] k);
      for (int a = 0; a < 4; a++) begin
         if (m_on[a] && (((k ^ m_key[a]) & m_care[a]) == 4'd0)) return {1'b1, 2'(a)};
      end
      return 3'b000;
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // Driver: called at a negedge while idle; queues the expected result.
   task automatic srch(input logic [3:0] k, input string req);
      srch_valid = 1'b1;
      srch_key   = k;
      exp_q.push_back(model(k));
      tag_q.push_back(req);
      @(negedge clk);
      srch_valid = 1'b0;
   endtask

   task automatic map_entry(input logic [1:0] a, input logic [3:0] k, input logic [3:0] c,
                            input bit poke);
      int n;
      map_valid = 1'b1;
      map_addr  = a;
      map_key   = k;
      map_care  = c;
      @(negedge clk);
      map_valid = 1'b0;
      n = 0;
      while (busy && n < 12) begin
         n++;
         if (poke && n == 1) begin
            // Offered during the walk: both must be dropped (R3).
            srch_valid = 1'b1;
            srch_key   = 4'b1000;
            map_valid  = 1'b1;
            map_addr   = 2'd0;
            map_key    = 4'b1000;
            map_care   = 4'b1111;
         end else begin
            srch_valid = 1'b0;
            map_valid  = 1'b0;
         end
         @(negedge clk);
      end
      srch_valid = 1'b0;
      map_valid  = 1'b0;
      chk("R3 busy cycles", n, 4);
      m_key[a]  = k;
      m_care[a] = c;
      m_on[a]   = 1'b1;
   endtask

   // Monitor: compares each result in arrival order.
   logic [2:0] mon_e;
   string      mon_t;
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2: unexpected result hit=%0d addr=%0d, expected none", res_hit, res_addr);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            if ({res_hit, res_addr} !== mon_e) begin
               fails++;
               $display("FAIL %s: got hit=%0d addr=%0d expected hit=%0d addr=%0d",
                        mon_t, res_hit, res_addr, mon_e[2], mon_e[1:0]);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      for (int a = 0; a < 4; a++) begin
         m_key[a] = '0; m_care[a] = '0; m_on[a] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 res_valid after reset", int'(res_valid), 0);
      srch(4'b0000, "R1 empty table");
      srch(4'b0011, "R1 empty table");

      // Layer 0: two exact entries with disjoint sub-words.
      map_entry(2'd0, 4'b0011, 4'b1111, 1'b0);
      map_entry(2'd1, 4'b1100, 4'b1111, 1'b0);
      srch(4'b0011, "R4 exact entry 0");
      srch(4'b1100, "R9 exact entry 1");
      srch(4'b0000, "R10 split sub-words");
      srch(4'b1111, "R10 split sub-words");
      srch(4'b0010, "R8 miss");

      // Layer 1 slot 1: 01XX, with traffic injected during the walk.
      map_entry(2'd3, 4'b0100, 4'b1100, 1'b1);
      srch(4'b1000, "R3 dropped mapping");
      srch(4'b0110, "R5 don't care");
      srch(4'b0100, "R5 don't care");
      srch(4'b0111, "R5 don't care");

      // Layer 1 slot 0: all don't care.
      map_entry(2'd2, 4'b0000, 4'b0000, 1'b0);
      srch(4'b1010, "R5 wildcard entry");
      srch(4'b0100, "R6 lowest slot in layer");
      srch(4'b1100, "R7 lowest layer");
      srch(4'b0011, "R7 lowest layer");
      srch(4'b0000, "R9 wildcard address");

      repeat (4) @(negedge clk);
      chk("R2 all results returned", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule